// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block chooses the address of the next instruction fetch for a 32-bit RISC core whose control transfers have a single branch delay slot. The instruction currently in decode supplies its own address, its 16-bit branch offset, its 26-bit jump index, both source register values and a set of decoded control flags. From these the unit evaluates the branch condition, forms the branch, jump or sequential target, and loads the program counter register. It also reports whether the transfer was taken, whether the instruction already fetched into the delay slot must be annulled, and whether a return address must be written to the link register.

The program counter register is part of the block. A stall input freezes it and the registered status outputs. An exception redirect input overrides every other decision, including a stall. When decode holds no valid instruction, the PC simply advances by one word.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` becomes 0 and `taken_o`, `squash_o`, `delay_slot_o` and `link_we_o` become 0.
- R2: When an edge accepts a decision (no stall, no exception) and either `dec_valid_i` is 0 or a branch is not taken, `pc_o` becomes its previous value plus 4 and `delay_slot_o` becomes 0.
- R3: An accepted jump with `ctl_jreg_i` = 0 loads `pc_o` with bits 31..28 of the current `pc_o` above `jidx_i` shifted left by 2 (bits 1..0 zero), and sets `taken_o`.
- R4: An accepted jump with `ctl_jreg_i` = 1 loads `pc_o` with `rs_val_i` and sets `taken_o`.
- R5: With `ctl_cmp_eq_i` = 1 the branch condition is `rs_val_i == rt_val_i`.
- R6: With `ctl_cmp_eq_i` = 0 and `ctl_lez_i` = 0 the branch condition is that `rs_val_i` is negative as a signed number.
- R7: With `ctl_cmp_eq_i` = 0 and `ctl_lez_i` = 1 the branch condition is that `rs_val_i` is less than or equal to zero as a signed number.
- R8: `ctl_invert_i` = 1 complements the branch condition chosen by R5 to R7.
- R9: A taken branch loads `pc_o` with `inst_addr_i + 4 + sign-extended (imm_i * 4)`; negative offsets move backwards.
- R10: An accepted branch with `ctl_likely_i` = 1 that is not taken sets `squash_o`; a taken likely branch, and every other decision, leaves `squash_o` at 0.
- R11: `delay_slot_o` becomes 1 after a taken branch or any jump, and 0 otherwise; `taken_o` follows the same rule.
- R12: An accepted valid decision with `ctl_link_i` = 1 sets `link_we_o` and loads `link_val_o` with `inst_addr_i + 8`; without it `link_we_o` becomes 0.
- R13: While `stall_i` is 1 and `exc_valid_i` is 0, `pc_o` and all status outputs keep their values.
- R14: `exc_valid_i` = 1 loads `pc_o` with `exc_target_i`, regardless of stall and control flags, and clears `taken_o`, `squash_o`, `delay_slot_o` and `link_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hold PC and status |
| exc_valid_i | input | 1 | Exception redirect request |
| exc_target_i | input | 32 | Exception handler address |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| inst_addr_i | input | 32 | Address of the instruction in decode |
| imm_i | input | 16 | Branch offset in words |
| jidx_i | input | 26 | Jump index field |
| rs_val_i | input | 32 | First source operand |
| rt_val_i | input | 32 | Second source operand |
| ctl_jump_i | input | 1 | Instruction is a jump |
| ctl_jreg_i | input | 1 | Jump target comes from the first operand |
| ctl_branch_i | input | 1 | Instruction is a conditional branch |
| ctl_cmp_eq_i | input | 1 | Condition compares both operands for equality |
| ctl_lez_i | input | 1 | Sign test includes zero |
| ctl_invert_i | input | 1 | Complement the condition |
| ctl_likely_i | input | 1 | Annul delay slot when not taken |
| ctl_link_i | input | 1 | Write return address |
| pc_o | output | 32 | Program counter |
| taken_o | output | 1 | Last accepted decision transferred control |
| squash_o | output | 1 | Delay-slot instruction must be annulled |
| delay_slot_o | output | 1 | Next fetched instruction is a delay slot |
| link_we_o | output | 1 | Link register write request |
| link_val_o | output | 32 | Return address |

## Verification
Each comparison kind is driven with operands on both sides of its boundary: equal and unequal pairs, the most negative value, zero and one for the sign tests, and all ones for the less-or-equal test, so that the zero case separates the two sign modes. The invert flag is applied to a case that would otherwise be taken and to one that would not. Branch offsets are tried both positive and negative to expose a missing sign extension, and an immediate jump is issued from a PC with non-zero upper bits to show those bits survive. Stall and exception are applied together with a taken branch, so a wrong priority shows up as a changed PC.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef struct packed {
    logic jump;
    logic jreg;
    logic branch;
    logic cmp_eq;
    logic lez;
    logic invert;
    logic likely;
    logic link;
  } npc_ctl_t;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JIMM = 2'd2,
    SEL_JREG = 2'd3
  } npc_sel_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cmp_eq_i,
  input  logic         lez_i,
  input  logic         invert_i,
  output logic         hit_o
);
  logic is_neg, is_zero, raw;

  always_comb begin
    is_neg  = a_i[W-1];
    is_zero = (a_i == '0);
    if (cmp_eq_i)   raw = (a_i == b_i);
    else if (lez_i) raw = is_neg | is_zero;
    else            raw = is_neg;
    hit_o = raw ^ invert_i;
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      inst_addr_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [W-1:0]      seq_o,
  output logic [W-1:0]      br_o,
  output logic [W-1:0]      jimm_o,
  output logic [W-1:0]      link_o
);
  localparam int OFS_W = IMM_W + 2;
  localparam int HI_W  = W - JIDX_W - 2;

  logic [OFS_W-1:0] ofs;
  logic [W-1:0]     ofs_ext;

  assign ofs     = {imm_i, 2'b00};
  assign ofs_ext = {{(W-OFS_W){ofs[OFS_W-1]}}, ofs};
  assign seq_o   = pc_i + W'(4);
  assign br_o    = inst_addr_i + W'(4) + ofs_ext;
  assign link_o  = inst_addr_i + W'(8);

  generate
    if (HI_W > 0) begin : g_keep_hi
      assign jimm_o = {pc_i[W-1 -: HI_W], jidx_i, 2'b00};
    end else begin : g_no_hi
      assign jimm_o = W'({jidx_i, 2'b00});
    end
  endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          W        = 32,
  parameter int          IMM_W    = 16,
  parameter int          JIDX_W   = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              exc_valid_i,
  input  logic [W-1:0]      exc_target_i,
  input  logic              dec_valid_i,
  input  logic [W-1:0]      inst_addr_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic [W-1:0]      rs_val_i,
  input  logic [W-1:0]      rt_val_i,
  input  logic              ctl_jump_i,
  input  logic              ctl_jreg_i,
  input  logic              ctl_branch_i,
  input  logic              ctl_cmp_eq_i,
  input  logic              ctl_lez_i,
  input  logic              ctl_invert_i,
  input  logic              ctl_likely_i,
  input  logic              ctl_link_i,
  output logic [W-1:0]      pc_o,
  output logic              taken_o,
  output logic              squash_o,
  output logic              delay_slot_o,
  output logic              link_we_o,
  output logic [W-1:0]      link_val_o
);
  import npc_pkg::*;

  npc_ctl_t ctl;
  npc_sel_e sel;
  logic [W-1:0] seq_tgt, br_tgt, jimm_tgt, link_tgt, next_pc;
  logic hit, take, annul;

  always_comb begin
    ctl        = '0;
    if (dec_valid_i) begin
      ctl.jump   = ctl_jump_i;
      ctl.jreg   = ctl_jreg_i;
      ctl.branch = ctl_branch_i;
      ctl.cmp_eq = ctl_cmp_eq_i;
      ctl.lez    = ctl_lez_i;
      ctl.invert = ctl_invert_i;
      ctl.likely = ctl_likely_i;
      ctl.link   = ctl_link_i;
    end
  end

  npc_cond #(.W(W)) i_cond (
    .a_i      (rs_val_i),
    .b_i      (rt_val_i),
    .cmp_eq_i (ctl.cmp_eq),
    .lez_i    (ctl.lez),
    .invert_i (ctl.invert),
    .hit_o    (hit)
  );

  npc_target #(.W(W), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) i_target (
    .pc_i        (pc_o),
    .inst_addr_i (inst_addr_i),
    .imm_i       (imm_i),
    .jidx_i      (jidx_i),
    .seq_o       (seq_tgt),
    .br_o        (br_tgt),
    .jimm_o      (jimm_tgt),
    .link_o      (link_tgt)
  );

  always_comb begin
    if (ctl.jump)                  sel = ctl.jreg ? SEL_JREG : SEL_JIMM;
    else if (ctl.branch && hit)    sel = SEL_BR;
    else                           sel = SEL_SEQ;
    take  = (sel != SEL_SEQ);
    annul = ctl.branch && ctl.likely && !take;
    case (sel)
      SEL_BR:   next_pc = br_tgt;
      SEL_JIMM: next_pc = jimm_tgt;
      SEL_JREG: next_pc = rs_val_i;
      default:  next_pc = seq_tgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o         <= W'(RESET_PC);
      taken_o      <= 1'b0;
      squash_o     <= 1'b0;
      delay_slot_o <= 1'b0;
      link_we_o    <= 1'b0;
      link_val_o   <= '0;
    end else if (exc_valid_i) begin
      pc_o         <= exc_target_i;
      taken_o      <= 1'b0;
      squash_o     <= 1'b0;
      delay_slot_o <= 1'b0;
      link_we_o    <= 1'b0;
    end else if (!stall_i) begin
      pc_o         <= next_pc;
      taken_o      <= take;
      squash_o     <= annul;
      delay_slot_o <= take;
      link_we_o    <= ctl.link;
      if (ctl.link) link_val_o <= link_tgt;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         stall_i,
  input logic         exc_valid_i,
  input logic [W-1:0] exc_target_i,
  input logic         dec_valid_i,
  input logic [W-1:0] inst_addr_i,
  input logic         ctl_link_i,
  input logic [W-1:0] pc_o,
  input logic         taken_o,
  input logic         squash_o,
  input logic         delay_slot_o,
  input logic         link_we_o,
  input logic [W-1:0] link_val_o
);
  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !exc_valid_i) |=> ($stable(pc_o) && $stable(taken_o) && $stable(squash_o)));

  // R14
  exc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid_i |=> (pc_o == $past(exc_target_i) && !taken_o && !squash_o && !link_we_o));

  // R10
  squash_excl_chk: assert property (@(posedge clk) disable iff (rst)
    squash_o |-> (!taken_o && !delay_slot_o));

  // R11
  slot_follow_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> delay_slot_o);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !exc_valid_i && !dec_valid_i) |=> (pc_o == $past(pc_o) + W'(4)));

  // R12
  link_val_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !exc_valid_i && dec_valid_i && ctl_link_i)
      |=> (link_we_o && link_val_o == $past(inst_addr_i) + W'(8)));
endmodule

bind npc_unit npc_unit_chk #(.W(W)) i_npc_unit_chk (
  .clk          (clk),
  .rst          (rst),
  .stall_i      (stall_i),
  .exc_valid_i  (exc_valid_i),
  .exc_target_i (exc_target_i),
  .dec_valid_i  (dec_valid_i),
  .inst_addr_i  (inst_addr_i),
  .ctl_link_i   (ctl_link_i),
  .pc_o         (pc_o),
  .taken_o      (taken_o),
  .squash_o     (squash_o),
  .delay_slot_o (delay_slot_o),
  .link_we_o    (link_we_o),
  .link_val_o   (link_val_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 0, exc_valid_i = 0, dec_valid_i = 0;
  logic [31:0] exc_target_i = 0, inst_addr_i = 0, rs_val_i = 0, rt_val_i = 0;
  logic [15:0] imm_i = 0;
  logic [25:0] jidx_i = 0;
  logic ctl_jump_i = 0, ctl_jreg_i = 0, ctl_branch_i = 0, ctl_cmp_eq_i = 0;
  logic ctl_lez_i = 0, ctl_invert_i = 0, ctl_likely_i = 0, ctl_link_i = 0;
  logic [31:0] pc_o, link_val_o;
  logic taken_o, squash_o, delay_slot_o, link_we_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] pc_before;

  always #2.5 clk = ~clk;

  npc_unit i_npc_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_ctl();
    dec_valid_i = 0; stall_i = 0; exc_valid_i = 0;
    ctl_jump_i = 0; ctl_jreg_i = 0; ctl_branch_i = 0; ctl_cmp_eq_i = 0;
    ctl_lez_i = 0; ctl_invert_i = 0; ctl_likely_i = 0; ctl_link_i = 0;
  endtask

  // one decision: drive at negedge, let one posedge pass, sample at next negedge
  task automatic branch_step(input logic [31:0] addr, input logic [15:0] imm,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic eq, input logic lez, input logic inv,
                             input logic likely);
    clear_ctl();
    dec_valid_i = 1; ctl_branch_i = 1; ctl_cmp_eq_i = eq; ctl_lez_i = lez;
    ctl_invert_i = inv; ctl_likely_i = likely;
    inst_addr_i = addr; imm_i = imm; rs_val_i = a; rt_val_i = b;
    pc_before = pc_o;
    @(negedge clk);
    clear_ctl();
  endtask

  task automatic t_reset();
    rst = 1; clear_ctl();
    repeat (3) @(negedge clk);
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 flags", {taken_o, squash_o, delay_slot_o, link_we_o}, 0);
    rst = 0;
  endtask

  task automatic t_sequential();
    clear_ctl(); @(negedge clk);
    chk("R2 idle pc+4", pc_o, 32'h4);
    chk("R2 slot", delay_slot_o, 0);
  endtask

  task automatic t_exception();
    clear_ctl();
    exc_valid_i = 1; exc_target_i = 32'hA000_0100; stall_i = 1;
    dec_valid_i = 1; ctl_jump_i = 1; ctl_jreg_i = 1; rs_val_i = 32'h5555_0000;
    ctl_link_i = 1;
    @(negedge clk); clear_ctl();
    chk("R14 exc pc", pc_o, 32'hA000_0100);
    chk("R14 flags", {taken_o, squash_o, delay_slot_o, link_we_o}, 0);
  endtask

  task automatic t_jump_imm();
    clear_ctl(); dec_valid_i = 1; ctl_jump_i = 1; jidx_i = 26'h0123456;
    @(negedge clk); clear_ctl();
    chk("R3 jump target", pc_o, 32'hA048_D158);
    chk("R11 jump taken/slot", {taken_o, delay_slot_o}, 2'b11);
    chk("R12 no link", link_we_o, 0);
  endtask

  task automatic t_jump_reg();
    clear_ctl(); dec_valid_i = 1; ctl_jump_i = 1; ctl_jreg_i = 1;
    rs_val_i = 32'h0040_0000; ctl_link_i = 1; inst_addr_i = 32'h0000_3000;
    @(negedge clk); clear_ctl();
    chk("R4 reg jump", pc_o, 32'h0040_0000);
    chk("R12 link we", link_we_o, 1);
    chk("R12 link val", link_val_o, 32'h0000_3008);
  endtask

  task automatic t_equal();
    branch_step(32'h0040_0000, 16'h0010, 32'h77, 32'h77, 1, 0, 0, 0);
    chk("R5 eq taken", pc_o, 32'h0040_0044);
    chk("R11 slot after taken", delay_slot_o, 1);
    branch_step(32'h0040_0044, 16'h0010, 32'h77, 32'h78, 1, 0, 0, 0);
    chk("R5 ne not taken", pc_o, pc_before + 4);
    chk("R11 not taken", {taken_o, delay_slot_o}, 0);
  endtask

  task automatic t_ltz();
    branch_step(32'h0000_1000, 16'hFFFE, 32'h8000_0000, 0, 0, 0, 0, 0);
    chk("R6/R9 ltz neg taken back", pc_o, 32'h0000_0FFC);
    branch_step(32'h0000_1000, 16'h0004, 32'h0, 0, 0, 0, 0, 0);
    chk("R6 ltz zero not taken", pc_o, pc_before + 4);
  endtask

  task automatic t_lez();
    branch_step(32'h0000_2000, 16'h0001, 32'h0, 0, 0, 1, 0, 0);
    chk("R7 lez zero taken", pc_o, 32'h0000_2008);
    branch_step(32'h0000_2000, 16'h0001, 32'h1, 0, 0, 1, 0, 0);
    chk("R7 lez one not taken", pc_o, pc_before + 4);
    branch_step(32'h0000_2000, 16'h8000, 32'hFFFF_FFFF, 0, 0, 1, 0, 0);
    chk("R7/R9 lez minus one, min offset", pc_o, 32'hFFFE_2004);
  endtask

  task automatic t_invert();
    branch_step(32'h0000_4000, 16'h0002, 32'h5, 0, 0, 0, 1, 0);
    chk("R8 inverted ltz taken", pc_o, 32'h0000_400C);
    branch_step(32'h0000_4000, 16'h0002, 32'h9, 32'h9, 1, 0, 1, 0);
    chk("R8 inverted eq not taken", pc_o, pc_before + 4);
    chk("R8 taken flag", taken_o, 0);
  endtask

  task automatic t_likely();
    branch_step(32'h0000_5000, 16'h0003, 32'h1, 32'h2, 1, 0, 0, 1);
    chk("R10 likely not taken squash", squash_o, 1);
    chk("R10 likely not taken pc", pc_o, pc_before + 4);
    branch_step(32'h0000_5000, 16'h0003, 32'h2, 32'h2, 1, 0, 0, 1);
    chk("R10 likely taken no squash", squash_o, 0);
    chk("R10 likely taken pc", pc_o, 32'h0000_5010);
    branch_step(32'h0000_5000, 16'h0003, 32'h1, 32'h2, 1, 0, 0, 0);
    chk("R10 plain not taken no squash", squash_o, 0);
  endtask

  task automatic t_stall();
    logic [31:0] held;
    branch_step(32'h0000_6000, 16'h0001, 32'h1, 32'h2, 1, 0, 0, 1);
    held = pc_o;
    clear_ctl(); stall_i = 1; dec_valid_i = 1; ctl_jump_i = 1; ctl_jreg_i = 1;
    rs_val_i = 32'h1234_5678; ctl_link_i = 1;
    @(negedge clk); @(negedge clk);
    chk("R13 stall pc", pc_o, held);
    chk("R13 stall flags", {taken_o, squash_o, link_we_o}, 3'b010);
    clear_ctl(); @(negedge clk);
    chk("R2 after stall", pc_o, held + 4);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_exception();
        t_jump_imm();
        t_jump_reg();
        t_equal();
        t_ltz();
        t_lez();
        t_invert();
        t_likely();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule